// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate SRAM Model

This block is a synthesizable behavioural model of a separate-I/O SRAM. It has an independent read port and an independent write port, and the two ports share one address bus. Every access moves a burst of four words. The differential input clock pair is modelled by one clock `clk` that runs at twice the word rate, together with a phase flag `kph`. An edge with `kph` = 0 stands for the rising edge of the true clock, and an edge with `kph` = 1 stands for the rising edge of the complement clock. Data moves on every edge, so each burst takes two full clock periods on its data port.

A write's four beats go into a burst buffer first. The buffer is committed to four banks one edge after the last beat arrives. A read returns four beats that are selected per lane from the banks and from the buffer, so a read always sees every write beat that arrived before the edge on which the read beat leaves. Read latency is selectable: one and a half periods in normal mode, or one period in short mode. When no beat is being driven, the output is in its modelled high-impedance state.

Top module: `qdr4_sram`

## Requirements
- R1: While reset is applied, and on the edges that follow it until a read returns, `q_vld` is 0 and `q` is all zeros.
- R2: `rd_sel_n` and `wr_sel_n` are active low and are sampled only on edges where `kph` = 0. A select that is low on a `kph` = 1 edge starts nothing.
- R3: A read is accepted on a `kph` = 0 edge when `rd_sel_n` is 0 and no read was accepted on the previous `kph` = 0 edge. Otherwise the select and the address are ignored.
- R4: A write is accepted on a `kph` = 0 edge when all three of these hold: `wr_sel_n` is 0, no write burst is still collecting beats, and no read is accepted on the same edge. A read takes the shared address bus first. A write select that is not accepted is ignored.
- R5: Write beat k (k = 0..3) is taken from `wdata` on the acceptance edge plus k edges, and it is stored as word k of the burst address.
- R6: `wlane_n[l]` is active low and qualifies bits 9l+8..9l of the beat sampled on the same edge. A beat lane whose enable is 1 leaves the stored lane unchanged.
- R7: A read accepted on edge A drives word k on `q`, with `q_vld` = 1, from edge A+3+k in normal mode and from edge A+2+k in short mode. There are exactly four beats, in word order.
- R8: On every edge that does not launch a read beat, `q_vld` is 0 and `q` is all zeros, which is the modelled high-impedance state. A pending burst still completes after the read select is removed.
- R9: Each read beat holds, lane by lane, the value of the most recent write beat to that word and lane that was captured on an earlier edge. This holds even if that write burst has not yet been committed to the banks.
- R10: `lat_one` (1 = short mode, 0 = normal mode) is taken on a read acceptance edge only if no earlier read is still waiting or returning data. Otherwise the previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each rising edge is one half period of the word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kph | input | 1 | Phase flag: 0 = true-clock edge, 1 = complement edge |
| rd_sel_n | input | 1 | Read select, active low |
| wr_sel_n | input | 1 | Write select, active low |
| addr | input | AW | Shared burst address |
| wdata | input | W | Write data beat |
| wlane_n | input | W/9 | Per-9-bit-lane write enables, active low |
| lat_one | input | 1 | Latency mode: 1 = one period, 0 = one and a half |
| q | output | W | Read data beat, zero while not driven |
| q_vld | output | 1 | High on every edge that carries a read beat |

## Verification
The bench goes after a read placed one period after a write to the same word. Here the read beats leave while the write burst is still in the buffer, so a design that reads only the banks returns stale lanes. It presents reads and writes together on the same edge, and selects on complement edges. A design that gives the bus to the write, or that samples on both phases, accepts a burst that should have been dropped, and that shows up later as wrong read data. It switches the latency mode between back-to-back reads. A design that takes the new mode at once makes two bursts collide or moves a burst by one edge, and the edge-by-edge comparison catches the shifted `q_vld` pattern.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;
  localparam int LANE_W = 9;
  localparam int BEATS  = 4;
  localparam int BW     = 2;

  typedef enum logic {
    LAT_HALF = 1'b0,
    LAT_ONE  = 1'b1
  } lat_e;
endpackage

// File: rtl/qdr4_rst_sync.sv
module qdr4_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/qdr4_wr_path.sv
module qdr4_wr_path
  import qdr4_pkg::*;
#(
  parameter int AW = 6,
  parameter int W  = 18,
  parameter int LN = W / LANE_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           kph,
  input  logic                           wr_sel_n,
  input  logic                           rd_take,
  input  logic [AW-1:0]                  addr,
  input  logic [W-1:0]                   wdata,
  input  logic [LN-1:0]                  wlane_n,
  output logic                           wr_take,
  output logic                           cm_en,
  output logic [AW-1:0]                  bf_addr,
  output logic [BEATS-1:0][W-1:0]        bf_data,
  output logic [BEATS-1:0][LN-1:0]       bf_mask
);
  logic                     act_q, act_n;
  logic [BW-1:0]            nb_q, nb_n;
  logic                     cm_q, cm_n;
  logic [AW-1:0]            addr_q, addr_n;
  logic [BEATS-1:0][W-1:0]  data_q, data_n;
  logic [BEATS-1:0][LN-1:0] mask_q, mask_n;
  logic [BW-1:0]            beat_sel;
  logic                     cap;
  logic                     ctl_en;

  // Next-state: burst acceptance and beat collection
  always_comb begin
    wr_take  = !kph && !wr_sel_n && !act_q && !rd_take;
    cap      = wr_take || act_q;
    beat_sel = wr_take ? '0 : nb_q;

    addr_n = wr_take ? addr : addr_q;

    data_n = data_q;
    if (cap) data_n[beat_sel] = wdata;

    mask_n = mask_q;
    if (wr_take || cm_q) mask_n = '0;
    if (cap) mask_n[beat_sel] = ~wlane_n;

    act_n  = wr_take || (act_q && (nb_q != BW'(BEATS - 1)));
    nb_n   = cap ? BW'(beat_sel + BW'(1)) : nb_q;
    cm_n   = act_q && (nb_q == BW'(BEATS - 1));
    ctl_en = cap || cm_q;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      nb_q   <= '0;
      cm_q   <= 1'b0;
      mask_q <= '0;
    end else if (ctl_en) begin
      act_q  <= act_n;
      nb_q   <= nb_n;
      cm_q   <= cm_n;
      mask_q <= mask_n;
    end
  end

  // Datapath registers
  always_ff @(posedge clk) begin
    if (wr_take) addr_q <= addr_n;
    if (cap)     data_q <= data_n;
  end

  assign cm_en   = cm_q;
  assign bf_addr = addr_q;
  assign bf_data = data_q;
  assign bf_mask = mask_q;
endmodule

// File: rtl/qdr4_array.sv
module qdr4_array
  import qdr4_pkg::*;
#(
  parameter int AW = 6,
  parameter int W  = 18,
  parameter int LN = W / LANE_W
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [BEATS-1:0][W-1:0]  wdata,
  input  logic [BEATS-1:0][LN-1:0] wmask,
  input  logic [AW-1:0]            raddr,
  output logic [BEATS-1:0][W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < BEATS; b++) begin : g_bank
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we) begin
        for (int l = 0; l < LN; l++) begin
          if (wmask[b][l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[b][l*LANE_W +: LANE_W];
        end
      end
    end

    assign rdata[b] = mem[raddr];
  end
endmodule

// File: rtl/qdr4_rd_path.sv
module qdr4_rd_path
  import qdr4_pkg::*;
#(
  parameter int AW = 6,
  parameter int W  = 18,
  parameter int LN = W / LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     kph,
  input  logic                     rd_sel_n,
  input  logic [AW-1:0]            addr,
  input  logic                     lat_one,
  output logic                     rd_take,
  output logic [AW-1:0]            ar_addr,
  input  logic [BEATS-1:0][W-1:0]  ar_data,
  input  logic [AW-1:0]            bf_addr,
  input  logic [BEATS-1:0][W-1:0]  bf_data,
  input  logic [BEATS-1:0][LN-1:0] bf_mask,
  output logic [W-1:0]             q,
  output logic                     q_vld
);
  localparam int NST = 3;

  logic [NST-1:0]         sv_q, sv_n;
  logic [NST-1:0][AW-1:0] sa_q, sa_n;
  lat_e                   lat_q, lat_n;
  logic                   eact_q, eact_n;
  logic [BW-1:0]          enb_q, enb_n;
  logic [AW-1:0]          eaddr_q, eaddr_n;
  logic [W-1:0]           q_q, q_n;
  logic                   vld_q, vld_n;

  logic          idle, launch, emit, hit;
  logic [AW-1:0] la, cur_addr;
  logic [BW-1:0] cur_beat;
  logic [W-1:0]  word;

  // Next-state: acceptance, stage pipeline, beat engine, lane merge
  always_comb begin
    rd_take = !kph && !rd_sel_n && !sv_q[1];
    idle    = (sv_q == '0) && !eact_q;
    lat_n   = (rd_take && idle) ? lat_e'(lat_one) : lat_q;

    sv_n    = {sv_q[NST-2:0], rd_take};
    sa_n    = {sa_q[NST-2:0], addr};

    launch  = (lat_q == LAT_ONE) ? sv_q[1] : sv_q[2];
    la      = (lat_q == LAT_ONE) ? sa_q[1] : sa_q[2];
    emit    = launch || eact_q;

    cur_beat = launch ? '0 : enb_q;
    cur_addr = launch ? la : eaddr_q;
    ar_addr  = cur_addr;

    hit  = (bf_addr == cur_addr);
    word = ar_data[cur_beat];
    for (int l = 0; l < LN; l++) begin
      if (hit && bf_mask[cur_beat][l]) word[l*LANE_W +: LANE_W] = bf_data[cur_beat][l*LANE_W +: LANE_W];
    end

    q_n   = emit ? word : '0;
    vld_n = emit;

    eact_n  = launch || (eact_q && (enb_q != BW'(BEATS - 1)));
    enb_n   = launch ? BW'(1) : (eact_q ? BW'(enb_q + BW'(1)) : enb_q);
    eaddr_n = launch ? la : eaddr_q;
  end

  // Control and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q   <= '0;
      lat_q  <= LAT_HALF;
      eact_q <= 1'b0;
      enb_q  <= '0;
      q_q    <= '0;
      vld_q  <= 1'b0;
    end else begin
      sv_q   <= sv_n;
      lat_q  <= lat_n;
      eact_q <= eact_n;
      enb_q  <= enb_n;
      q_q    <= q_n;
      vld_q  <= vld_n;
    end
  end

  // Address pipeline, no reset
  always_ff @(posedge clk) begin
    sa_q <= sa_n;
    if (launch) eaddr_q <= eaddr_n;
  end

  assign q     = q_q;
  assign q_vld = vld_q;
endmodule

// File: rtl/qdr4_sram.sv
module qdr4_sram
  import qdr4_pkg::*;
#(
  parameter int AW = 6,
  parameter int W  = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 kph,
  input  logic                 rd_sel_n,
  input  logic                 wr_sel_n,
  input  logic [AW-1:0]        addr,
  input  logic [W-1:0]         wdata,
  input  logic [W/LANE_W-1:0]  wlane_n,
  input  logic                 lat_one,
  output logic [W-1:0]         q,
  output logic                 q_vld
);
  localparam int LN = W / LANE_W;

  logic                     rst_n_s;
  logic                     rd_take, wr_take, cm_en;
  logic [AW-1:0]            bf_addr, ar_addr;
  logic [BEATS-1:0][W-1:0]  bf_data, ar_data;
  logic [BEATS-1:0][LN-1:0] bf_mask;

  qdr4_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  qdr4_wr_path #(.AW(AW), .W(W), .LN(LN)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .kph      (kph),
    .wr_sel_n (wr_sel_n),
    .rd_take  (rd_take),
    .addr     (addr),
    .wdata    (wdata),
    .wlane_n  (wlane_n),
    .wr_take  (wr_take),
    .cm_en    (cm_en),
    .bf_addr  (bf_addr),
    .bf_data  (bf_data),
    .bf_mask  (bf_mask)
  );

  qdr4_array #(.AW(AW), .W(W), .LN(LN)) u_mem (
    .clk   (clk),
    .we    (cm_en),
    .waddr (bf_addr),
    .wdata (bf_data),
    .wmask (bf_mask),
    .raddr (ar_addr),
    .rdata (ar_data)
  );

  qdr4_rd_path #(.AW(AW), .W(W), .LN(LN)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .kph      (kph),
    .rd_sel_n (rd_sel_n),
    .addr     (addr),
    .lat_one  (lat_one),
    .rd_take  (rd_take),
    .ar_addr  (ar_addr),
    .ar_data  (ar_data),
    .bf_addr  (bf_addr),
    .bf_data  (bf_data),
    .bf_mask  (bf_mask),
    .q        (q),
    .q_vld    (q_vld)
  );
endmodule

// File: rtl/qdr4_sram_chk.sv
module qdr4_sram_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n_s,
  input logic         rd_take,
  input logic         wr_take,
  input logic         cm_en,
  input logic         q_vld,
  input logic [W-1:0] q
);
  // R3: no read accepted on the three edges after an acceptance
  p_rd_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_take |=> !rd_take ##1 !rd_take ##1 !rd_take);

  // R4: no write accepted while a burst still collects beats
  p_wr_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_take |=> !wr_take ##1 !wr_take ##1 !wr_take);

  // R5: a collected burst is committed four edges after acceptance
  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_take |-> ##4 cm_en);

  // R7: an accepted read is returning data within either latency
  p_read_returns_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_take |-> ##4 q_vld);

  // R7: a returned burst is at least four beats long
  p_burst_len_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(q_vld) |-> ##1 q_vld ##1 q_vld ##1 q_vld);

  // R8: the undriven output reads as zero
  p_tristate_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !q_vld |-> (q == '0));
endmodule

bind qdr4_sram qdr4_sram_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n_s (rst_n_s),
  .rd_take (rd_take),
  .wr_take (wr_take),
  .cm_en   (cm_en),
  .q_vld   (q_vld),
  .q       (q)
);

// File: tb/qdr4_sram_bench.sv
module qdr4_sram_bench;
  localparam int AW = 4;
  localparam int W  = 18;
  localparam int LN = W / 9;
  localparam int ND = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          kph = 1'b1;
  logic          rs = 1'b1, ws = 1'b1, lm = 1'b0;
  logic [AW-1:0] a = '0;
  logic [W-1:0]  d = '0;
  logic [LN-1:0] be = '1;
  logic [W-1:0]  q;
  logic          q_vld;

  int    n_chk = 0, n_fail = 0;
  bit    chk_on = 1'b0, done = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  qdr4_sram #(.AW(AW), .W(W)) u_qdr4_sram (
    .clk(clk), .rst_n(rst_n), .kph(kph), .rd_sel_n(rs), .wr_sel_n(ws),
    .addr(a), .wdata(d), .wlane_n(be), .lat_one(lm), .q(q), .q_vld(q_vld)
  );

  // Reference model, built from the requirements
  logic [W-1:0]  ref_mem [ND][4];
  bit            sv [16];
  int            sa [16], sb [16];
  int            edge_n, lastA, lastL, m_wrem, m_wb, m_wa;
  bit            m_rd_prev, have_rd, m_lat, cur_v;
  logic [W-1:0]  cur_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      edge_n = 0; m_wrem = 0; m_rd_prev = 0; have_rd = 0; m_lat = 0; cur_v = 0; cur_q = '0;
      for (int i = 0; i < 16; i++) sv[i] = 0;
    end else begin
      bit rt, wt;
      int L, s;
      edge_n++;
      s = edge_n % 16;
      cur_v = sv[s];
      cur_q = cur_v ? ref_mem[sa[s]][sb[s]] : '0;
      sv[s] = 0;
      rt = !kph && !rs && !m_rd_prev;                  // R2 R3
      if (!kph) m_rd_prev = rt;
      wt = !kph && !ws && (m_wrem == 0) && !rt;         // R4
      if (rt) begin
        if (!(have_rd && edge_n <= lastA + lastL + 3)) m_lat = lm;   // R10
        L = m_lat ? 2 : 3;                                          // R7
        lastA = edge_n; lastL = L; have_rd = 1;
        for (int k = 0; k < 4; k++) begin
          sv[(edge_n + L + k) % 16] = 1;
          sa[(edge_n + L + k) % 16] = int'(a);
          sb[(edge_n + L + k) % 16] = k;
        end
      end
      if (wt) begin
        m_wa = int'(a); m_wb = 0; m_wrem = 3;
      end else if (m_wrem > 0) begin
        m_wb++; m_wrem--;
      end
      if (wt || m_wb > 0 && (m_wrem > 0 || m_wb == 3) && !wt && (m_wrem + m_wb == 3)) begin
        for (int l = 0; l < LN; l++)                    // R5 R6
          if (!be[l]) ref_mem[m_wa][m_wb][l*9 +: 9] = d[l*9 +: 9];
      end
      if (m_wrem == 0 && m_wb == 3) m_wb = 0;
    end
  end

  // Edge-by-edge comparison of the read port (R7 R8 R9)
  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_chk++;
      if (q_vld !== cur_v || q !== cur_q) begin
        n_fail++;
        $display("FAIL %s edge %0d: q_vld=%0b q=%h, expected q_vld=%0b q=%h",
                 tag, edge_n, q_vld, q, cur_v, cur_q);
      end
    end
  end

  task automatic step(input logic r, input logic w, input logic [AW-1:0] ad,
                      input logic [LN-1:0] ben, input logic l);
    @(negedge clk);
    kph = ~kph; rs = r; ws = w; a = ad; d = W'($urandom); be = ben; lm = l;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, '0, '1, lm);
  endtask

  task automatic align;
    if (kph == 1'b0) idle(1);
  endtask

  task automatic wr_burst(input logic [AW-1:0] ad, input bit full);
    align;
    step(1, 0, ad, full ? '0 : LN'($urandom), lm);
    for (int k = 1; k < 4; k++) step(1, 1, '0, full ? '0 : LN'($urandom), lm);
  endtask

  task automatic rd_burst(input logic [AW-1:0] ad, input logic l);
    align;
    step(0, 1, ad, '1, l);
    for (int k = 1; k < 4; k++) step(1, 1, '0, '1, l);
  endtask

  initial begin
    idle(3);
    n_chk++;                                            // R1 reset state
    if (q_vld !== 1'b0 || q !== '0) begin
      n_fail++;
      $display("FAIL R1: q_vld=%0b q=%h, expected q_vld=0 q=0", q_vld, q);
    end
    rst_n = 1'b1;
    chk_on = 1'b1;
    idle(6);

    tag = "R5 prefill";
    for (int i = 0; i < ND; i++) wr_burst(AW'(i), 1'b1);
    idle(4);

    tag = "R7 normal latency readback";
    for (int i = 0; i < ND; i++) rd_burst(AW'(i), 1'b0);
    idle(8);

    tag = "R7 R10 short latency readback";
    for (int i = 0; i < ND; i++) rd_burst(AW'(i), 1'b1);
    idle(8);

    tag = "R6 R9 masked write then read one period later";
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < ND; i++) begin
        align;
        step(1, 0, AW'(i), LN'($urandom), m[0]);
        step(1, 1, '0, LN'($urandom), m[0]);
        step(0, 1, AW'(i), LN'($urandom), m[0]);
        step(1, 1, '0, LN'($urandom), m[0]);
        idle(4);
      end
      idle(8);
    end

    tag = "R4 read and write on the same edge";
    for (int i = 0; i < ND; i++) begin
      align;
      step(0, 0, AW'(i), '0, 1'b0);
      idle(7);
      rd_burst(AW'(i), 1'b0);
    end
    idle(8);

    tag = "R10 mode change with read in flight";
    for (int i = 0; i < 8; i++) begin
      rd_burst(AW'(i), i[0]);
      rd_burst(AW'(i + 1), ~i[0]);
      idle(10);
    end

    for (int sec = 0; sec < 3; sec++) begin
      tag = (sec == 2) ? "R2 R3 R4 R9 R10 random traffic, mode varies"
                       : "R2 R3 R4 R6 R8 R9 random traffic";
      for (int i = 0; i < 3000; i++) begin
        logic l;
        l = (sec == 2) ? 1'($urandom) : sec[0];
        step(1'($urandom), 1'($urandom), AW'($urandom), LN'($urandom), l);
      end
      idle(12);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule